// File: doc/BRIEF.md
# Latched Status Interrupt Controller

This block gathers a set of slow board-level status signals into sticky latch bits and raises one active-low interrupt request when any latched bit is also enabled. The sources are the four serial modem status lines, an alarm input, a flash-busy input, a card-ready input, a line-invalid condition, and a card-present condition. The line-invalid and card-present conditions each drive two latch bits, one for each polarity. Software can therefore be told both when a condition starts and when it ends.

Each input passes through a flip-flop synchroniser. In the default edge mode, a latch bit is set when its synchronised condition goes from inactive to active. In level mode, a latch bit is set on every cycle in which its condition is active. A 16-bit register bus gives software access to three registers that share one bit layout: the latch register (read-only), the mask register (read/write), and the clear register (write-one-to-clear). A clear on a bit only takes effect when that bit's condition is inactive at the time of the write. This stops a condition that is still present from being silently acknowledged.

Top module: `status_irq_latch`

## Requirements
- R1: After reset, the latch register (address 0) and the mask register (address 1) read 0x0000, and `irq_n` is 1.
- R2: The layout shared by the latch, mask and clear registers is: bit 0 CTS, bit 1 DSR, bit 2 DCD, bit 3 RI, bit 4 alarm, bit 5 flash busy, bit 6 card ready. In edge mode, a bit becomes 1 in the latch register when its input goes from 0 to 1. The new value is readable after at most four clock edges.
- R3: A latch bit stays 1 after its input returns to 0, until it is cleared.
- R4: `irq_n` is 0 exactly when some bit is 1 in both the latch register and the mask register; otherwise it is 1.
- R5: Writing 1 to a bit of the clear register (address 2) clears that latch bit if its condition is inactive. Writing 0 changes nothing.
- R6: A clear written while the bit's condition is still active leaves the latch bit set.
- R7: The mask register stores only the implemented bits (mask 0x0F7F); all other bits read 0. Writes to address 0 are ignored. Addresses 2 and 3 read 0x0000.
- R8: Bit 8 latches when the line becomes invalid, and bit 9 when it becomes valid again. Bit 10 latches when a card is inserted, and bit 11 when it is removed.
- R9: With `LEVEL_SET` = 1, a latch bit is set on every cycle in which its synchronised condition is active. This includes right after reset, when the line is valid and no card is present, so the latch register reads 0x0A00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modem_cts | input | 1 | Clear-to-send status, active high |
| modem_dsr | input | 1 | Data-set-ready status, active high |
| modem_dcd | input | 1 | Carrier-detect status, active high |
| modem_ri | input | 1 | Ring-indicator status, active high |
| alarm_in | input | 1 | Alarm request, active high |
| flash_busy | input | 1 | Flash busy, active high |
| card_ready | input | 1 | Card ready, active high |
| line_invalid | input | 1 | 1 when all serial line receivers see invalid levels |
| card_present | input | 1 | 1 when a card is inserted |
| bus_addr | input | 2 | Register select: 0 latch, 1 mask, 2 clear |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds two instances on the same inputs and the same bus. One uses the defaults (two synchroniser stages, edge mode). The other sets `LEVEL_SET` = 1. The edge-mode instance covers the following:
- walking each source through set, hold and clear;
- the blocked clear while a source is still active;
- both polarities of the paired conditions.

The level-mode instance makes it possible to check the reset-time latching of the line-valid and card-absent bits. It also checks that a clear cannot remove a bit whose condition persists.

// File: rtl/status_irq_latch.sv
module status_irq_latch #(
  parameter int SYNC_STAGES = 2,
  parameter bit LEVEL_SET   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        modem_cts,
  input  logic        modem_dsr,
  input  logic        modem_dcd,
  input  logic        modem_ri,
  input  logic        alarm_in,
  input  logic        flash_busy,
  input  logic        card_ready,
  input  logic        line_invalid,
  input  logic        card_present,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq_n
);
  localparam int          NSRC    = 9;
  localparam logic [15:0] IMPL    = 16'h0F7F;
  localparam logic [15:0] RST_ACT = 16'h0A00;

  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] sync_q [SYNC_STAGES];
  logic [NSRC-1:0] s;
  logic [15:0]     act_now, act_q, set_v, clr_v, latch_q, mask_q;

  assign raw = {card_present, line_invalid, card_ready, flash_busy,
                alarm_in, modem_ri, modem_dcd, modem_dsr, modem_cts};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end

  assign s       = sync_q[SYNC_STAGES-1];
  assign act_now = {4'b0, ~s[8], s[8], ~s[7], s[7], 1'b0, s[6:0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) act_q <= RST_ACT;
    else        act_q <= act_now;

  generate
    if (LEVEL_SET) begin : g_level
      assign set_v = act_now;
    end else begin : g_edge
      assign set_v = act_now & ~act_q;
    end
  endgenerate

  assign clr_v = (bus_wr && bus_addr == 2'd2) ? (bus_wdata & ~act_now) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      latch_q <= '0;
      mask_q  <= '0;
    end else begin
      latch_q <= ((latch_q & ~clr_v) | set_v) & IMPL;
      if (bus_wr && bus_addr == 2'd1) mask_q <= bus_wdata & IMPL;
    end

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = latch_q;
      2'd1:    bus_rdata = mask_q;
      default: bus_rdata = '0;
    endcase

  assign irq_n = ~|(latch_q & mask_q);
endmodule

// File: rtl/status_irq_latch_chk.sv
module status_irq_latch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_addr,
  input logic        bus_wr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic        irq_n,
  input logic [15:0] latch_q,
  input logic [15:0] act_now
);
  logic clr_wr;
  assign clr_wr = bus_wr && bus_addr == 2'd2;

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (latch_q == 16'h0000));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

  assert_irq_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(bus_wr));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((latch_q & $past(bus_wdata & ~act_now)) == 16'h0000));

  assert_clear_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((latch_q & $past(bus_wdata & latch_q & act_now))
                == $past(bus_wdata & latch_q & act_now)));

  assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & 16'hF080) == 16'h0000);
endmodule

bind status_irq_latch status_irq_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n),
  .latch_q(latch_q), .act_now(act_now)
);

// File: tb/sim_status_irq_latch.sv
`timescale 1ns/1ps
module sim_status_irq_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] mdm = '0;
  logic line_invalid = 1'b0, card_present = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] rd0, rd1;
  logic irq0, irq1;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  status_irq_latch u0 (
    .clk(clk), .rst_n(rst_n), .modem_cts(mdm[0]), .modem_dsr(mdm[1]),
    .modem_dcd(mdm[2]), .modem_ri(mdm[3]), .alarm_in(mdm[4]),
    .flash_busy(mdm[5]), .card_ready(mdm[6]), .line_invalid(line_invalid),
    .card_present(card_present), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .irq_n(irq0));

  status_irq_latch #(.LEVEL_SET(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .modem_cts(mdm[0]), .modem_dsr(mdm[1]),
    .modem_dcd(mdm[2]), .modem_ri(mdm[3]), .alarm_in(mdm[4]),
    .flash_busy(mdm[5]), .card_ready(mdm[6]), .line_invalid(line_invalid),
    .card_present(card_present), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .irq_n(irq1));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    bus_addr = a;
    #1;
  endtask

  task automatic t_reset_r1();
    rd(2'd0); chk("R1 latch", rd0, 16'h0000);
    rd(2'd1); chk("R1 mask", rd0, 16'h0000);
    chk("R1 irq_n", {15'b0, irq0}, 16'h0001);
  endtask

  task automatic t_level_r9();
    rd(2'd0); chk("R9 level reset latch", rd1, 16'h0A00);
    wr(2'd2, 16'hFFFF);
    rd(2'd0); chk("R9 clear blocked while active", rd1, 16'h0A00);
    wr(2'd1, 16'h0200);
    chk("R9 level irq", {15'b0, irq1}, 16'h0000);
    chk("R4 edge irq idle", {15'b0, irq0}, 16'h0001);
    wr(2'd1, 16'h0000);
    chk("R9 irq released by mask", {15'b0, irq1}, 16'h0001);
  endtask

  task automatic t_walk_r2();
    for (int i = 0; i < 7; i++) begin
      mdm[i] = 1'b1; settle();
      rd(2'd0); chk("R2 source bit", rd0, 16'(1) << i);
      mdm[i] = 1'b0; settle();
      wr(2'd2, 16'(1) << i);
      rd(2'd0); chk("R5 walk clear", rd0, 16'h0000);
    end
  endtask

  task automatic t_sticky_r3();
    mdm[0] = 1'b1; settle();
    mdm[0] = 1'b0; settle();
    rd(2'd0); chk("R3 sticky after drop", rd0, 16'h0001);
  endtask

  task automatic t_irq_r4();
    chk("R4 unmasked irq high", {15'b0, irq0}, 16'h0001);
    wr(2'd1, 16'h0002);
    chk("R4 other mask irq high", {15'b0, irq0}, 16'h0001);
    wr(2'd1, 16'h0001);
    chk("R4 masked irq low", {15'b0, irq0}, 16'h0000);
  endtask

  task automatic t_clear_r5();
    wr(2'd2, 16'h0000);
    rd(2'd0); chk("R5 zero write no effect", rd0, 16'h0001);
    wr(2'd2, 16'h0001);
    rd(2'd0); chk("R5 clear", rd0, 16'h0000);
    chk("R5 irq released", {15'b0, irq0}, 16'h0001);
  endtask

  task automatic t_blocked_r6();
    mdm[1] = 1'b1; settle();
    wr(2'd2, 16'h0002);
    rd(2'd0); chk("R6 clear while active", rd0, 16'h0002);
    mdm[1] = 1'b0; settle();
    wr(2'd2, 16'h0002);
    rd(2'd0); chk("R6 clear after inactive", rd0, 16'h0000);
  endtask

  task automatic t_regs_r7();
    wr(2'd1, 16'hFFFF);
    rd(2'd1); chk("R7 mask implemented bits", rd0, 16'h0F7F);
    wr(2'd0, 16'hFFFF);
    rd(2'd0); chk("R7 latch write ignored", rd0, 16'h0000);
    rd(2'd2); chk("R7 clear reads zero", rd0, 16'h0000);
    rd(2'd3); chk("R7 addr3 reads zero", rd0, 16'h0000);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_pairs_r8();
    line_invalid = 1'b1; settle();
    rd(2'd0); chk("R8 line invalid", rd0, 16'h0100);
    line_invalid = 1'b0; settle();
    rd(2'd0); chk("R8 line valid again", rd0, 16'h0300);
    card_present = 1'b1; settle();
    rd(2'd0); chk("R8 card inserted", rd0, 16'h0700);
    card_present = 1'b0; settle();
    rd(2'd0); chk("R8 card removed", rd0, 16'h0F00);
    wr(2'd2, 16'hFFFF);
    rd(2'd0); chk("R6 active pair bits kept", rd0, 16'h0A00);
    wr(2'd1, 16'h0800);
    chk("R4 removal irq", {15'b0, irq0}, 16'h0000);
    wr(2'd1, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_r1();
    t_level_r9();
    t_walk_r2();
    t_sticky_r3();
    t_irq_r4();
    t_clear_r5();
    t_blocked_r6();
    t_regs_r7();
    t_pairs_r8();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule